// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This controller gathers interrupt requests from seven maskable sources and one non-maskable line, and decides which one the processor services next. The maskable sources are, in tie-break order, a timer, two DMA channels and four external request lines. Each maskable source has a 3-bit priority level that software can program. Each source also has a fixed vector type. The controller drives that vector type to the processor alongside its interrupt request, and the processor uses it to index its service-routine table.

Each accepted interrupt sets an in-service bit. The in-service bits decide whether a new request may nest over the routine that is already running. Two nesting rules are available. The strict rule lets a request nest only if its level is higher than every level in service. The relaxed rule also lets a request at the same level as an in-service external line nest. Software programs the levels, the mask, the enable and the nesting rule through an 8-bit write/read port. It ends an interrupt by writing to an end-of-interrupt address.

Top module: `irq_prio_ctrl`

## Requirements
- R1: When `req_i[k]` is high at a clock edge, source k's pending bit is set and held until that source is acknowledged. An acknowledge (`ack_i` high at an edge while `irq_o` is high) clears the winner's pending bit and sets its in-service bit.
- R2: Among the enabled, unmasked pending sources, the one with the numerically smallest level wins (level 0 is the highest priority). Ties go to the lower source index: 0 timer, 1 DMA0, 2 DMA1, 3..6 external lines 0..3.
- R3: `vector_o` carries the winner's fixed type: NMI 2, timer 8, DMA0 10, DMA1 11, external lines 0..3 give 12..15.
- R4: A rising edge on `nmi_i` makes the NMI pending. A pending NMI always beats every maskable source and ignores the mask and the enable. While the NMI is in service, nothing is forwarded, including a new NMI. Holding `nmi_i` high does not retrigger it.
- R5: With the nesting-mode bit clear, a maskable request is forwarded only if its level is strictly smaller than the smallest in-service level.
- R6: With the nesting-mode bit set, a request is also forwarded when its level equals the smallest in-service level and an external line (index 3..6) is in service at that level.
- R7: A write to address 10 ends an interrupt. It clears the NMI in-service bit if that bit is set. Otherwise it clears the in-service bit of the highest-priority in-service source, using the R2 order.
- R8: Address 8 holds one mask bit per source, with bit k belonging to source k. A masked request is never forwarded but stays pending. Once the source is unmasked, it is forwarded.
- R9: Bit 0 of address 9 is the global enable. While it is 0, no maskable source is forwarded, but requests still latch as pending.
- R10: Register map and reset values:
  - Addresses 0..6 hold the level of source k in bits 2:0; each resets to 7.
  - Address 8 is the mask; it resets to 0x7F.
  - Address 9 holds the enable in bit 0 and the nesting mode in bit 1; it resets to 0.
  - Reading address 10 returns the in-service bits, with the NMI in bit 7.
  - Reading address 11 returns the pending bits, with the NMI in bit 7.
  - After reset, `irq_o` is 0.
- R11: An `ack_i` while `irq_o` is low changes nothing. `vector_o` is 0 whenever `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| nmi_i | input | 1 | Non-maskable request, edge sensitive |
| req_i | input | 7 | Maskable requests, indexed as in R2 |
| ack_i | input | 1 | Processor acknowledge of the presented interrupt |
| irq_o | output | 1 | Interrupt request to the processor |
| vector_o | output | 8 | Vector type of the presented interrupt |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data (combinational) |

## Verification
The bench builds the block with its default parameters: seven sources and 3-bit levels. With that size, every pair of simultaneous sources can be swept over low, middle and equal levels. Every ordered pair of in-service source and newcomer is also swept, under both nesting rules, at levels one above, equal to and one below the in-service level. Expected winners, vectors and nesting outcomes are computed arithmetically from the levels and indices. Directed sequences cover masking, the global enable, NMI edge behaviour, end-of-interrupt order and idle acknowledges.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;
  localparam logic [ADDR_W-1:0] REG_MASK = 4'd8;
  localparam logic [ADDR_W-1:0] REG_CTRL = 4'd9;
  localparam logic [ADDR_W-1:0] REG_EOI  = 4'd10;
  localparam logic [ADDR_W-1:0] REG_PEND = 4'd11;
  localparam logic [7:0] NMI_VEC = 8'd2;

  // timer -> 8, DMA0/DMA1 -> 10/11, external lines -> 12..15
  function automatic logic [7:0] src_vec(input int idx);
    return (idx == 0) ? 8'd8 : 8'(9 + idx);
  endfunction
endpackage

// File: rtl/prio_pick.sv
module prio_pick #(
  parameter int N  = 7,
  parameter int LW = 3,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]         valid_i,
  input  logic [N-1:0][LW-1:0] lvl_i,
  output logic                 found_o,
  output logic [IW-1:0]        idx_o,
  output logic [LW-1:0]        lvl_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    lvl_o   = '1;
    // strict compare keeps the lowest index on ties
    for (int i = 0; i < N; i++) begin
      if (valid_i[i] && (!found_o || lvl_i[i] < lvl_o)) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
        lvl_o   = lvl_i[i];
      end
    end
  end
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_prio_pkg::*;
#(
  parameter int N  = 7,
  parameter int LW = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  input  logic [N-1:0]         pend_i,
  input  logic                 nmi_pend_i,
  input  logic [N-1:0]         isr_i,
  input  logic                 nmi_isr_i,
  output logic [N-1:0][LW-1:0] lvl_o,
  output logic [N-1:0]         mask_o,
  output logic                 en_o,
  output logic                 sfnm_o,
  output logic                 eoi_o,
  output logic [DATA_W-1:0]    rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_o  <= '1;
      mask_o <= '1;
      en_o   <= 1'b0;
      sfnm_o <= 1'b0;
    end else if (we_i) begin
      for (int k = 0; k < N; k++)
        if (addr_i == ADDR_W'(k)) lvl_o[k] <= wdata_i[LW-1:0];
      if (addr_i == REG_MASK) mask_o <= wdata_i[N-1:0];
      if (addr_i == REG_CTRL) begin
        en_o   <= wdata_i[0];
        sfnm_o <= wdata_i[1];
      end
    end
  end

  assign eoi_o = we_i && (addr_i == REG_EOI);

  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < N; k++)
      if (addr_i == ADDR_W'(k)) rdata_o = DATA_W'(lvl_o[k]);
    case (addr_i)
      REG_MASK: rdata_o = DATA_W'(mask_o);
      REG_CTRL: rdata_o = DATA_W'({sfnm_o, en_o});
      REG_EOI:  rdata_o = {nmi_isr_i, (DATA_W-1)'(isr_i)};
      REG_PEND: rdata_o = {nmi_pend_i, (DATA_W-1)'(pend_i)};
      default: ;
    endcase
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int N_SRC    = 7,
  parameter int LVL_W    = 3,
  parameter int EXT_BASE = 3,
  localparam int IW = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              nmi_i,
  input  logic [N_SRC-1:0]  req_i,
  input  logic              ack_i,
  output logic              irq_o,
  output logic [7:0]        vector_o,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [N_SRC-1:0]            pend_q, isr_q, mask_q, elig, ack_set, eoi_clr;
  logic [N_SRC-1:0][LVL_W-1:0] lvl;
  logic                        nmi_q, nmi_pend_q, nmi_isr_q, en_q, sfnm_q, eoi;
  logic                        p_found, s_found, ext_at_min, nest_ok, nmi_fire, take;
  logic [IW-1:0]               p_idx, s_idx;
  logic [LVL_W-1:0]            p_lvl, s_lvl;

  irq_regs #(.N(N_SRC), .LW(LVL_W)) u_regs (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i,
    .pend_i(pend_q), .nmi_pend_i(nmi_pend_q), .isr_i(isr_q), .nmi_isr_i(nmi_isr_q),
    .lvl_o(lvl), .mask_o(mask_q), .en_o(en_q), .sfnm_o(sfnm_q), .eoi_o(eoi),
    .rdata_o
  );

  assign elig = pend_q & ~mask_q & {N_SRC{en_q}};

  prio_pick #(.N(N_SRC), .LW(LVL_W)) u_pick_req (
    .valid_i(elig), .lvl_i(lvl), .found_o(p_found), .idx_o(p_idx), .lvl_o(p_lvl)
  );

  prio_pick #(.N(N_SRC), .LW(LVL_W)) u_pick_isr (
    .valid_i(isr_q), .lvl_i(lvl), .found_o(s_found), .idx_o(s_idx), .lvl_o(s_lvl)
  );

  always_comb begin
    ext_at_min = 1'b0;
    for (int k = EXT_BASE; k < N_SRC; k++)
      if (isr_q[k] && lvl[k] == s_lvl) ext_at_min = 1'b1;
  end

  assign nest_ok  = !s_found || (p_lvl < s_lvl) || (sfnm_q && p_lvl == s_lvl && ext_at_min);
  assign nmi_fire = nmi_pend_q && !nmi_isr_q;
  assign irq_o    = nmi_fire || (!nmi_isr_q && p_found && nest_ok);
  assign vector_o = nmi_fire ? NMI_VEC : (irq_o ? src_vec(int'(p_idx)) : 8'd0);
  assign take     = ack_i && irq_o;

  always_comb begin
    ack_set = '0;
    eoi_clr = '0;
    if (take && !nmi_fire) ack_set[p_idx] = 1'b1;
    if (eoi && !nmi_isr_q && s_found) eoi_clr[s_idx] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nmi_q      <= 1'b0;
      nmi_pend_q <= 1'b0;
      nmi_isr_q  <= 1'b0;
      pend_q     <= '0;
      isr_q      <= '0;
    end else begin
      nmi_q      <= nmi_i;
      nmi_pend_q <= (nmi_pend_q && !(take && nmi_fire)) || (nmi_i && !nmi_q);
      nmi_isr_q  <= (nmi_isr_q && !eoi) || (take && nmi_fire);
      pend_q     <= (pend_q & ~ack_set) | req_i;
      isr_q      <= (isr_q & ~eoi_clr) | ack_set;
    end
  end
endmodule

// File: rtl/irq_prio_chk.sv
module irq_prio_chk
  import irq_prio_pkg::*;
#(
  parameter int N = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ack_i,
  input logic              irq_o,
  input logic [7:0]        vector_o,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [N-1:0]      pend_q,
  input logic [N-1:0]      mask_q,
  input logic [N-1:0]      isr_q,
  input logic              en_q,
  input logic              nmi_pend_q,
  input logic              nmi_isr_q
);
  // R11
  idle_vec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> vector_o == 8'd0);
  // R4
  nmi_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nmi_pend_q && !nmi_isr_q) |-> (irq_o && vector_o == NMI_VEC));
  // R4
  nmi_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_isr_q |-> !irq_o);
  // R9
  gate_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |-> (!irq_o || vector_o == NMI_VEC));
  // R8
  mask_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_q & $past(pend_q & mask_q)) == $past(pend_q & mask_q)));
  // R1
  ack_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_o && vector_o != NMI_VEC) |=> isr_q != '0);
  // R11
  ack_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !irq_o && !(we_i && addr_i == REG_EOI)) |=>
      (isr_q == $past(isr_q) && nmi_isr_q == $past(nmi_isr_q)));
endmodule

bind irq_prio_ctrl irq_prio_chk #(.N(N_SRC)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ack_i(ack_i), .irq_o(irq_o), .vector_o(vector_o),
  .we_i(we_i), .addr_i(addr_i), .pend_q(pend_q), .mask_q(mask_q), .isr_q(isr_q),
  .en_q(en_q), .nmi_pend_q(nmi_pend_q), .nmi_isr_q(nmi_isr_q)
);

// File: tb/irq_prio_ctrl_bench.sv
`timescale 1ns/1ps
module irq_prio_ctrl_bench;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       nmi = 1'b0, ack = 1'b0, we = 1'b0;
  logic [6:0] req = '0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0, rdata, vec;
  logic       irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_prio_ctrl u_irq_prio_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .nmi_i(nmi), .req_i(req), .ack_i(ack),
    .irq_o(irq), .vector_o(vec), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata)
  );

  function automatic int exp_vec(int s);
    case (s)
      0: return 8;  1: return 10; 2: return 11; 3: return 12;
      4: return 13; 5: return 14; default: return 15;
    endcase
  endfunction

  task automatic chk(bit ok, string rq, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk); we = 1; addr = 4'(a); wdata = 8'(d);
    @(negedge clk); we = 0;
  endtask

  task automatic rd_chk(int a, int exp, string rq);
    @(negedge clk); addr = 4'(a); #1;
    chk(rdata == 8'(exp), rq, rdata, exp);
  endtask

  task automatic pulse(int m);
    @(negedge clk); req = 7'(m);
    @(negedge clk); req = '0;
  endtask

  task automatic do_ack();
    @(negedge clk); ack = 1;
    @(negedge clk); ack = 0;
  endtask

  task automatic out_chk(bit e_irq, int e_vec, string rq);
    #1;
    chk(irq == e_irq, rq, irq, e_irq);
    if (e_irq) chk(vec == 8'(e_vec), rq, vec, e_vec);
    else       chk(vec == 8'd0, rq, vec, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R10 reset state
    out_chk(0, 0, "R10");
    rd_chk(0, 7, "R10"); rd_chk(6, 7, "R10");
    rd_chk(8, 8'h7F, "R10"); rd_chk(9, 0, "R10");
    rd_chk(10, 0, "R10"); rd_chk(11, 0, "R10");
    wr(8, 0); wr(9, 1);

    // R3 R1 each source alone
    for (int s = 0; s < 7; s++) begin
      pulse(1 << s);
      out_chk(1, exp_vec(s), "R3");
      rd_chk(11, 1 << s, "R1");
      do_ack();
      rd_chk(10, 1 << s, "R1");
      rd_chk(11, 0, "R1");
      wr(10, 0);
      rd_chk(10, 0, "R7");
    end

    // R11 idle acknowledge
    do_ack();
    rd_chk(10, 0, "R11");
    out_chk(0, 0, "R11");

    // R2 R5 all pairs, several levels
    for (int i = 0; i < 7; i++)
      for (int j = i + 1; j < 7; j++)
        for (int a = 0; a < 3; a++)
          for (int b = 0; b < 3; b++) begin
            int la, lb, w, l;
            la = (a == 0) ? 0 : (a == 1) ? 3 : 7;
            lb = (b == 0) ? 0 : (b == 1) ? 3 : 7;
            wr(i, la); wr(j, lb);
            pulse((1 << i) | (1 << j));
            w = (lb < la) ? j : i;
            l = (w == i) ? j : i;
            out_chk(1, exp_vec(w), "R2");
            do_ack();
            out_chk(0, 0, "R5");
            wr(10, 0);
            out_chk(1, exp_vec(l), "R7");
            do_ack(); wr(10, 0);
          end
    for (int k = 0; k < 7; k++) wr(k, 7);

    // R5 R6 nesting sweep under both modes
    for (int m = 0; m < 2; m++) begin
      wr(9, 1 | (m << 1));
      for (int a = 0; a < 7; a++)
        for (int b = 0; b < 7; b++)
          if (a != b)
            for (int lb = 2; lb <= 4; lb++) begin
              bit e;
              wr(a, 3); wr(b, lb);
              pulse(1 << a); do_ack();
              pulse(1 << b);
              e = (lb < 3) || (m == 1 && lb == 3 && a >= 3);
              if (m == 1) out_chk(e, exp_vec(b), "R6");
              else        out_chk(e, exp_vec(b), "R5");
              if (e) begin
                do_ack(); wr(10, 0); wr(10, 0);
              end else begin
                wr(10, 0);
                out_chk(1, exp_vec(b), "R7");
                do_ack(); wr(10, 0);
              end
              rd_chk(10, 0, "R7");
              wr(a, 7); wr(b, 7);
            end
    end
    wr(9, 1);

    // R8 mask keeps pending
    wr(8, 8'h10);
    pulse(1 << 4);
    out_chk(0, 0, "R8");
    rd_chk(11, 8'h10, "R8");
    wr(8, 0);
    out_chk(1, 13, "R8");
    do_ack(); wr(10, 0);

    // R9 global enable
    wr(9, 0);
    pulse(1 << 2);
    out_chk(0, 0, "R9");
    rd_chk(11, 8'h04, "R9");
    wr(9, 1);
    out_chk(1, 11, "R9");
    do_ack(); wr(10, 0);

    // R7 end-of-interrupt order
    wr(5, 5); wr(1, 2);
    pulse(1 << 5); do_ack();
    pulse(1 << 1);
    out_chk(1, 10, "R5");
    do_ack();
    rd_chk(10, 8'h22, "R7");
    wr(10, 0);
    rd_chk(10, 8'h20, "R7");
    wr(10, 0);
    rd_chk(10, 0, "R7");
    wr(5, 7); wr(1, 7);

    // R4 NMI
    wr(0, 0);
    pulse(1 << 0);
    out_chk(1, 8, "R4");
    @(negedge clk); nmi = 1;
    @(negedge clk);
    out_chk(1, 2, "R4");
    do_ack();
    out_chk(0, 0, "R4");
    rd_chk(10, 8'h80, "R4");
    repeat (3) @(negedge clk);
    out_chk(0, 0, "R4");
    wr(10, 0);
    rd_chk(10, 0, "R7");
    rd_chk(11, 8'h01, "R4");
    out_chk(1, 8, "R4");
    do_ack(); wr(10, 0);
    nmi = 0;
    wr(9, 0); wr(8, 8'h7F);
    @(negedge clk); nmi = 1;
    @(negedge clk); nmi = 0;
    out_chk(1, 2, "R4");
    do_ack(); wr(10, 0);
    out_chk(0, 0, "R4");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule